// File: doc/BRIEF.md
# Serial audio receiver

This block assembles sample words from a serial data line paced by a bit clock and marked by a frame sync. Static configuration inputs choose several things. The bit clock can come from a pin or be divided down from the system clock. The frame sync can come from a pin or be generated inside the block. Further inputs pick the latching edge, the sync polarity, a one-bit or one-word sync width, a sync that is aligned with the first data bit or leads it by one bit, and whether the bits arrive most-significant first or least-significant first. A 4-bit code selects the sample width.

Pin inputs are brought into the system clock domain through flop synchronizers. The bit clock is treated as data: the block acts on its edges and never uses it as a clock. Each completed word appears right-aligned on a parallel output, with a strobe that lasts one cycle. The output is a valid-only stream. A serial line cannot be held back, so there is no ready input and the consumer must accept every word in the cycle the strobe is high. The configuration is meant to change only while the block is held in reset or the line is idle.

Top module: `sar_rx`

## Requirements
- R1: With `cfg_clk_int`=1 the block drives `bclk_o` with `bclk_oe`=1, and the level toggles every `cfg_div_half` system cycles. With `cfg_clk_int`=0, `bclk_oe`=0 and edges of `bclk_i` pace reception.
- R2: With `cfg_fs_int`=1 the block drives the generated sync on `fs_o` with `fs_oe`=1. With `cfg_fs_int`=0, `fs_oe`=0 and frame starts are taken from `fs_i`.
- R3: `cfg_lsb_first`=0 takes the first received bit as the most significant bit of the word. `cfg_lsb_first`=1 takes it as bit 0.
- R4: `cfg_rise_latch`=1 samples data and sync on rising bit-clock edges and `cfg_rise_latch`=0 on falling edges. A generated sync changes on the opposite edge.
- R5: `cfg_fs_active_low`=0 means the sync pin is active high and 1 means it is active low. This applies to both `fs_i` and `fs_o`.
- R6: A generated sync stays active for one bit period when `cfg_fs_bitlen`=1 and for as many bit periods as the word length when `cfg_fs_bitlen`=0. A received sync is recognised by its leading edge in both widths.
- R7: With `cfg_fs_early`=0 the bit sampled together with the sync's leading edge is the first data bit. With `cfg_fs_early`=1 the first data bit is the one sampled on the next latching edge.
- R8: The word-length code maps 0..7 to 8, 10, 12, 16, 18, 20, 22 and 24 bits. Codes 8..15 select 16 bits.
- R9: After the last bit of a word is sampled, `word_valid_o` is high for exactly one cycle. `word_o` then holds the word right-aligned, with all bits above the word length at zero.
- R10: A new sync leading edge in the middle of a word discards the partial word and starts a new one. Only the new word is delivered.
- R11: After reset, `word_valid_o`=0, `word_o`=0, and with internal sources selected `fs_o` is inactive.
- R12: A generated sync has its leading edge every `cfg_frame_bits` bit periods. `cfg_frame_bits` must be at least the word length plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_clk_int | input | 1 | 1: generate the bit clock, 0: use bclk_i |
| cfg_fs_int | input | 1 | 1: generate the frame sync, 0: use fs_i |
| cfg_lsb_first | input | 1 | Bit order, 1 = least significant first |
| cfg_rise_latch | input | 1 | 1: sample on rising edge, 0: falling |
| cfg_fs_active_low | input | 1 | Sync pin polarity, 1 = active low |
| cfg_fs_bitlen | input | 1 | Generated sync width, 1 = one bit, 0 = one word |
| cfg_fs_early | input | 1 | 1: sync leads the first data bit by one bit |
| cfg_wl_code | input | 4 | Word-length code |
| cfg_div_half | input | 8 | Internal bit-clock half period in system cycles |
| cfg_frame_bits | input | 6 | Bit periods per generated frame |
| bclk_i | input | 1 | External bit clock |
| bclk_o | output | 1 | Generated bit clock |
| bclk_oe | output | 1 | Output enable for the bit-clock pin |
| fs_i | input | 1 | External frame sync |
| fs_o | output | 1 | Generated frame sync, polarity applied |
| fs_oe | output | 1 | Output enable for the sync pin |
| sdata_i | input | 1 | Serial data |
| word_o | output | 24 | Received word, right-aligned |
| word_valid_o | output | 1 | One-cycle strobe for word_o |

## Verification
Words are sent through the external pins in a set of vectors. Each vector crosses bit order, latching edge, sync polarity, sync width and early/aligned timing, and the vectors together cover every word-length code plus one reserved code. The data patterns are asymmetric, so a reversed bit order, a one-bit slip from the wrong sync timing, or a wrong mask at the top of the word each give a different value. A truncated frame followed at once by a full frame separates a correct restart from a merged word. The two internal-source runs measure the bit-clock half period, the sync width and the frame period on the pins, which separates the one-bit and one-word sync widths and a wrong frame length.

// File: rtl/sar_pkg.sv
package sar_pkg;

  localparam int unsigned SAR_WMAX = 24;
  localparam int unsigned SAR_WL_W = $clog2(SAR_WMAX + 1);

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_ARMED = 2'd1,
    RX_RECV  = 2'd2
  } rx_state_e;

  // word-length code to bit count; unlisted codes fall back to 16
  function automatic logic [SAR_WL_W-1:0] sar_wl_bits(input logic [3:0] code);
    logic [SAR_WL_W-1:0] r;
    case (code)
      4'd0:    r = SAR_WL_W'(8);
      4'd1:    r = SAR_WL_W'(10);
      4'd2:    r = SAR_WL_W'(12);
      4'd3:    r = SAR_WL_W'(16);
      4'd4:    r = SAR_WL_W'(18);
      4'd5:    r = SAR_WL_W'(20);
      4'd6:    r = SAR_WL_W'(22);
      4'd7:    r = SAR_WL_W'(24);
      default: r = SAR_WL_W'(16);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/sar_bclk_gen.sv
module sar_bclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] half,
  output logic             bclk
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] limit;

  assign limit = (half == '0) ? DIV_W'(1) : half;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt  <= '0;
      bclk <= 1'b0;
    end else if (cnt >= limit - 1'b1) begin
      cnt  <= '0;
      bclk <= ~bclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sar_fs_gen.sv
module sar_fs_gen #(
  parameter int FRM_W = 6,
  parameter int WL_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drv,
  input  logic [FRM_W-1:0] frame_bits,
  input  logic [WL_W-1:0]  wl,
  input  logic             bitlen,
  input  logic             early,
  output logic             fs_act
);
  logic [FRM_W-1:0] slot;
  logic [FRM_W-1:0] nxt_slot;
  logic [FRM_W-1:0] last;
  logic [FRM_W-1:0] wl_ext;
  logic             fs_nxt;

  assign last   = frame_bits - 1'b1;
  assign wl_ext = FRM_W'(wl);

  always_comb begin
    nxt_slot = (slot >= last) ? '0 : slot + 1'b1;
    if (early)
      fs_nxt = bitlen ? (nxt_slot == last)
                      : ((nxt_slot == last) || (nxt_slot < wl_ext - 1'b1));
    else
      fs_nxt = bitlen ? (nxt_slot == '0) : (nxt_slot < wl_ext);
  end

  // slot resets to all ones so the first drive edge opens slot 0
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot   <= '1;
      fs_act <= 1'b0;
    end else if (drv) begin
      slot   <= nxt_slot;
      fs_act <= fs_nxt;
    end
  end
endmodule

// File: rtl/sar_deser.sv
module sar_deser
  import sar_pkg::*;
#(
  parameter int W    = 24,
  parameter int WL_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lat,
  input  logic            fs_act,
  input  logic            sd,
  input  logic [WL_W-1:0] wl,
  input  logic            lsb_first,
  input  logic            early,
  output logic [W-1:0]    word,
  output logic            valid
);
  rx_state_e       state;
  logic            fs_last;
  logic [WL_W-1:0] cnt;
  logic [W-1:0]    sh;

  logic            start, take_first, take_next, done;
  logic [W-1:0]    base_sh, new_sh;
  logic [WL_W-1:0] base_cnt, new_cnt;

  always_comb begin
    start      = fs_act & ~fs_last;
    take_first = start ? ~early : (state == RX_ARMED);
    take_next  = ~start & (state == RX_RECV);
    base_sh    = take_first ? '0 : sh;
    base_cnt   = take_first ? '0 : cnt;
    if (lsb_first) new_sh = base_sh | (W'(sd) << base_cnt);
    else           new_sh = {base_sh[W-2:0], sd};
    new_cnt    = base_cnt + 1'b1;
    done       = (new_cnt == wl);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= RX_IDLE;
      fs_last <= 1'b0;
      cnt     <= '0;
      sh      <= '0;
      word    <= '0;
      valid   <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (lat) begin
        fs_last <= fs_act;
        if (take_first || take_next) begin
          sh  <= new_sh;
          cnt <= new_cnt;
          if (done) begin
            state <= RX_IDLE;
            word  <= new_sh;
            valid <= 1'b1;
          end else begin
            state <= RX_RECV;
          end
        end else if (start) begin
          state <= RX_ARMED;
          cnt   <= '0;
          sh    <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/sar_rx.sv
module sar_rx
  import sar_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int FRM_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_clk_int,
  input  logic                cfg_fs_int,
  input  logic                cfg_lsb_first,
  input  logic                cfg_rise_latch,
  input  logic                cfg_fs_active_low,
  input  logic                cfg_fs_bitlen,
  input  logic                cfg_fs_early,
  input  logic [3:0]          cfg_wl_code,
  input  logic [DIV_W-1:0]    cfg_div_half,
  input  logic [FRM_W-1:0]    cfg_frame_bits,
  input  logic                bclk_i,
  output logic                bclk_o,
  output logic                bclk_oe,
  input  logic                fs_i,
  output logic                fs_o,
  output logic                fs_oe,
  input  logic                sdata_i,
  output logic [SAR_WMAX-1:0] word_o,
  output logic                word_valid_o
);
  localparam int WL_W = SAR_WL_W;

  logic            bclk_s, fs_s, sd_s;
  logic            gen_bclk, gen_fs;
  logic            bclk_sel, bclk_q;
  logic            rise, fall;
  logic            lat_pulse, drv_pulse;
  logic            fs_act;
  logic [WL_W-1:0] wl;

  assign wl = sar_wl_bits(cfg_wl_code);

  sar_sync #(.STAGES(SYNC_STAGES)) u_sync_bclk (.clk(clk), .rst_n(rst_n), .d(bclk_i),  .q(bclk_s));
  sar_sync #(.STAGES(SYNC_STAGES)) u_sync_fs   (.clk(clk), .rst_n(rst_n), .d(fs_i),    .q(fs_s));
  sar_sync #(.STAGES(SYNC_STAGES)) u_sync_sd   (.clk(clk), .rst_n(rst_n), .d(sdata_i), .q(sd_s));

  sar_bclk_gen #(.DIV_W(DIV_W)) u_bclk_gen (
    .clk(clk), .rst_n(rst_n), .en(cfg_clk_int), .half(cfg_div_half), .bclk(gen_bclk)
  );

  assign bclk_sel = cfg_clk_int ? gen_bclk : bclk_s;

  always_ff @(posedge clk) begin
    if (!rst_n) bclk_q <= 1'b0;
    else        bclk_q <= bclk_sel;
  end

  assign rise      = bclk_sel & ~bclk_q;
  assign fall      = ~bclk_sel & bclk_q;
  assign lat_pulse = cfg_rise_latch ? rise : fall;
  assign drv_pulse = cfg_rise_latch ? fall : rise;

  sar_fs_gen #(.FRM_W(FRM_W), .WL_W(WL_W)) u_fs_gen (
    .clk(clk), .rst_n(rst_n), .drv(drv_pulse), .frame_bits(cfg_frame_bits),
    .wl(wl), .bitlen(cfg_fs_bitlen), .early(cfg_fs_early), .fs_act(gen_fs)
  );

  assign fs_act = cfg_fs_int ? gen_fs : (fs_s ^ cfg_fs_active_low);

  sar_deser #(.W(SAR_WMAX), .WL_W(WL_W)) u_deser (
    .clk(clk), .rst_n(rst_n), .lat(lat_pulse), .fs_act(fs_act), .sd(sd_s),
    .wl(wl), .lsb_first(cfg_lsb_first), .early(cfg_fs_early),
    .word(word_o), .valid(word_valid_o)
  );

  assign bclk_o  = gen_bclk;
  assign bclk_oe = cfg_clk_int;
  assign fs_o    = gen_fs ^ cfg_fs_active_low;
  assign fs_oe   = cfg_fs_int;
endmodule

// File: rtl/sar_rx_chk.sv
module sar_rx_chk
  import sar_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic [3:0]          cfg_wl_code,
  input logic                cfg_fs_int,
  input logic                cfg_fs_active_low,
  input logic                fs_o,
  input logic [SAR_WMAX-1:0] word_o,
  input logic                word_valid_o,
  input logic                lat_pulse,
  input logic                drv_pulse
);
  logic [SAR_WL_W-1:0] chk_wl;
  assign chk_wl = sar_wl_bits(cfg_wl_code);

  assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |=> !word_valid_o);

  assert_word_fits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> ((word_o >> chk_wl) == '0));

  assert_valid_after_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> $past(lat_pulse));

  assert_fs_on_drive_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_fs_int && $stable(cfg_fs_int) && $stable(cfg_fs_active_low) && (fs_o != $past(fs_o)))
      |-> $past(drv_pulse));
endmodule

bind sar_rx sar_rx_chk u_sar_rx_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wl_code(cfg_wl_code), .cfg_fs_int(cfg_fs_int),
  .cfg_fs_active_low(cfg_fs_active_low), .fs_o(fs_o), .word_o(word_o),
  .word_valid_o(word_valid_o), .lat_pulse(lat_pulse), .drv_pulse(drv_pulse)
);

// File: tb/tb_sar_rx.sv
module tb_sar_rx;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_clk_int = 0, cfg_fs_int = 0, cfg_lsb_first = 0, cfg_rise_latch = 1;
  logic cfg_fs_active_low = 0, cfg_fs_bitlen = 1, cfg_fs_early = 0;
  logic [3:0] cfg_wl_code = 4'd0;
  logic [7:0] cfg_div_half = 8'd6;
  logic [5:0] cfg_frame_bits = 6'd12;
  logic bclk_i = 1'b0, fs_i = 1'b0, sdata_i = 1'b0;
  logic bclk_o, bclk_oe, fs_o, fs_oe, word_valid_o;
  logic [23:0] word_o;

  int nchk = 0, nfail = 0;
  int vcnt = 0, dbl = 0;
  logic prev_v = 1'b0;
  logic [23:0] last_word = '0;

  always #5 clk = ~clk;

  sar_rx dut (
    .clk(clk), .rst_n(rst_n), .cfg_clk_int(cfg_clk_int), .cfg_fs_int(cfg_fs_int),
    .cfg_lsb_first(cfg_lsb_first), .cfg_rise_latch(cfg_rise_latch),
    .cfg_fs_active_low(cfg_fs_active_low), .cfg_fs_bitlen(cfg_fs_bitlen),
    .cfg_fs_early(cfg_fs_early), .cfg_wl_code(cfg_wl_code), .cfg_div_half(cfg_div_half),
    .cfg_frame_bits(cfg_frame_bits), .bclk_i(bclk_i), .bclk_o(bclk_o), .bclk_oe(bclk_oe),
    .fs_i(fs_i), .fs_o(fs_o), .fs_oe(fs_oe), .sdata_i(sdata_i), .word_o(word_o),
    .word_valid_o(word_valid_o)
  );

  always @(negedge clk) begin
    if (!rst_n) prev_v = 1'b0;
    else begin
      if (word_valid_o) begin
        vcnt++;
        last_word = word_o;
        if (prev_v) dbl++;
      end
      prev_v = word_valid_o;
    end
  end

  function automatic int wl_of(input logic [3:0] c);
    case (c)
      4'd0: return 8;  4'd1: return 10; 4'd2: return 12; 4'd3: return 16;
      4'd4: return 18; 4'd5: return 20; 4'd6: return 22; 4'd7: return 24;
      default: return 16;
    endcase
  endfunction

  function automatic logic bit_at(input logic [23:0] d, input int wl, input int pos, input logic lsb);
    if (pos < 0 || pos >= wl) return 1'b0;
    return lsb ? d[pos] : d[wl-1-pos];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // one bit period on the external pins: drive edge, then latch edge
  task automatic slot(input logic d, input logic act);
    bclk_i  = cfg_rise_latch ? 1'b0 : 1'b1;
    sdata_i = d;
    fs_i    = act ^ cfg_fs_active_low;
    repeat (HALF) @(negedge clk);
    bclk_i  = cfg_rise_latch ? 1'b1 : 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic ext_frame(input logic [23:0] d, input int start_s, input int stop_s);
    int wl;
    logic act;
    wl = wl_of(cfg_wl_code);
    for (int s = start_s; s <= stop_s; s++) begin
      if (cfg_fs_early) act = cfg_fs_bitlen ? (s == -1) : (s >= -1 && s <= wl - 2);
      else              act = cfg_fs_bitlen ? (s == 0)  : (s >= 0 && s <= wl - 1);
      slot(bit_at(d, wl, s, cfg_lsb_first), act);
    end
  endtask

  task automatic ext_setup(input logic [32:0] v);
    cfg_clk_int = 0; cfg_fs_int = 0;
    cfg_lsb_first = v[32]; cfg_rise_latch = v[31]; cfg_fs_active_low = v[30];
    cfg_fs_bitlen = v[29]; cfg_fs_early = v[28]; cfg_wl_code = v[27:24];
    bclk_i = cfg_rise_latch; fs_i = cfg_fs_active_low; sdata_i = 1'b0;
    do_reset();
    slot(1'b0, 1'b0);
    slot(1'b0, 1'b0);
  endtask

  // {lsb_first, rise_latch, active_low, bitlen, early, wl_code, data}
  localparam logic [32:0] VEC [0:8] = '{
    {1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd0, 24'h0000A5},
    {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3, 24'h00BEEF},
    {1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd7, 24'hC35A96},
    {1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 4'd1, 24'h0002D3},
    {1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd5, 24'h09F0E1},
    {1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'hC, 24'hFF1234},
    {1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'd2, 24'h000F0E},
    {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd6, 24'h2AAAA9},
    {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd4, 24'h03C0F3}
  };

  task automatic run_internal(input logic rise, input logic inv, input logic bitlen,
                              input logic early, input logic lsb, input logic [3:0] code,
                              input logic [23:0] d, input logic [5:0] fbits);
    int wl, pos, edges, last_rise, nrise, period, curlen, fslen, since, hmin, hmax, v0;
    logic pb, pend, pact, act;
    logic [23:0] exp;
    cfg_clk_int = 1; cfg_fs_int = 1; cfg_rise_latch = rise; cfg_fs_active_low = inv;
    cfg_fs_bitlen = bitlen; cfg_fs_early = early; cfg_lsb_first = lsb; cfg_wl_code = code;
    cfg_div_half = 8'd6; cfg_frame_bits = fbits; sdata_i = 1'b0;
    wl = wl_of(code);
    exp = d & ((24'd1 << wl) - 24'd1);
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R11 fs_o inactive in reset", {31'd0, fs_o}, {31'd0, inv});
    chk("R11 valid low in reset", {31'd0, word_valid_o}, 32'd0);
    rst_n = 1'b1;
    v0 = vcnt;
    pos = 1000; edges = 0; last_rise = 0; nrise = 0; period = -1; curlen = 0; fslen = -1;
    since = -1; hmin = 9999; hmax = 0; pb = bclk_o; pend = 0; pact = 0;
    for (int i = 0; i < 12 * fbits * 4; i++) begin
      @(negedge clk);
      if (since >= 0) since++;
      if (bclk_o != pb) begin
        if (since > 0) begin
          if (since < hmin) hmin = since;
          if (since > hmax) hmax = since;
        end
        since = 0;
        if (rise ? (pb && !bclk_o) : (!pb && bclk_o)) pend = 1;
        pb = bclk_o;
      end else if (pend) begin
        pend = 0;
        act = fs_o ^ inv;
        if (act && !pact) begin
          if (nrise > 0) period = edges - last_rise;
          last_rise = edges;
          nrise++;
          pos = early ? -1 : 0;
          curlen = 1;
        end else begin
          pos++;
          if (act) curlen++;
          else if (pact) fslen = curlen;
        end
        pact = act;
        edges++;
        sdata_i = bit_at(d, wl, pos, lsb);
      end
    end
    chk("R1 bclk_oe", {31'd0, bclk_oe}, 32'd1);
    chk("R2 fs_oe", {31'd0, fs_oe}, 32'd1);
    chk("R1 half period min", hmin, 32'd6);
    chk("R1 half period max", hmax, 32'd6);
    chk("R6 generated sync width", fslen, bitlen ? 32'd1 : wl);
    chk("R12 frame period", period, {26'd0, fbits});
    chk("R2 words received >= 2", {31'd0, (vcnt - v0) >= 2}, 32'd1);
    chk("R7 internal word", {8'd0, last_word}, {8'd0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    int v0;
    logic [32:0] v;
    logic [23:0] exp;
    // R11: reset state with external sources
    do_reset();
    chk("R11 word_o after reset", {8'd0, word_o}, 32'd0);
    chk("R11 valid after reset", {31'd0, word_valid_o}, 32'd0);
    chk("R1 bclk_oe external", {31'd0, bclk_oe}, 32'd0);
    chk("R2 fs_oe external", {31'd0, fs_oe}, 32'd0);

    // table walk: R3 R4 R5 R7 R8 R9 across the vectors
    for (int k = 0; k < 9; k++) begin
      v = VEC[k];
      ext_setup(v);
      v0 = vcnt;
      ext_frame(v[23:0], -1, wl_of(v[27:24]) - 1);
      slot(1'b0, 1'b0);
      slot(1'b0, 1'b0);
      exp = v[23:0] & ((24'd1 << wl_of(v[27:24])) - 24'd1);
      chk($sformatf("R9 one word per frame vec%0d", k), vcnt - v0, 32'd1);
      chk($sformatf("R3 R4 R5 R7 R8 word vec%0d", k), {8'd0, last_word}, {8'd0, exp});
    end

    // R10: truncated word, then a full frame right behind it
    ext_setup({1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd0, 24'd0});
    v0 = vcnt;
    ext_frame(24'h0000FF, 0, 4);
    ext_frame(24'h00003C, 0, 7);
    slot(1'b0, 1'b0);
    slot(1'b0, 1'b0);
    chk("R10 single word after restart", vcnt - v0, 32'd1);
    chk("R10 restarted word", {8'd0, last_word}, 32'h3C);

    // R5: sync of the wrong polarity starts nothing
    ext_setup({1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd0, 24'd0});
    v0 = vcnt;
    for (int s = 0; s < 12; s++) slot(1'b1, 1'b0);
    chk("R5 idle-level sync ignored", vcnt - v0, 32'd0);

    // R1 R2 R6 R12 internal sources
    run_internal(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 24'h0000A5, 6'd12);
    run_internal(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'd1, 24'h0002C9, 6'd14);

    chk("R9 no back-to-back strobes", dbl, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule